// File: doc/BRIEF.md
# Receive Input Selector with DC Offset Removal

This block sits at the front of a receive chain, ahead of a downconverter. It takes two signed sample streams from a pair of converters, here called A and B. For each of the two downconverter inputs, I and Q, it picks which converter feeds that input, or whether the input is held at zero. It then takes a DC offset out of each path before passing the samples on.

Each path has its own offset mode. In automatic mode a leaky integrator follows the mean of the corrected signal and subtracts its estimate. In fixed mode a 14-bit value written by software is subtracted instead. Writing a fixed value also loads it into the integrator, so a later switch back to automatic mode starts from that value rather than from a stale estimate. Subtraction saturates to the signed sample range. Corrected samples leave the block one cycle after the input strobe.

Configuration goes through a small write port with three word addresses: the source selector, the I offset word and the Q offset word.

Top module: `rxfe_front`

## Requirements
- R1: After reset, `outValid` is 0 and `outI`/`outQ` are 0. The selector routes converter A to I and converter B to Q, which is a selector word of 0x4. Both paths are in automatic mode with an estimate of zero.
- R2: A write (`cfgWrEn`=1) to address 0 sets the selector from `cfgWrData[3:0]`. Address 1 writes the I offset word and address 2 writes the Q offset word. Address 3 is ignored. A write takes effect for samples presented in later cycles.
- R3: Selector bits [1:0] choose the I source and bits [3:2] choose the Q source. Code 00 selects converter A, 01 selects converter B, and 10 or 11 selects a constant zero.
- R4: An offset word with bit 31 set puts its path in fixed mode. The path then subtracts `cfgWrData[13:0]`, read as a signed 14-bit value, from each sample.
- R5: The result of the subtraction saturates to the range -8192..8191 and never wraps.
- R6: In automatic mode each path keeps an 18-bit accumulator (14 + SHIFT bits, SHIFT=4). The estimate is the accumulator arithmetically shifted right by SHIFT, that is floor(acc/16). The output is sat(sample − estimate). The saturated output is then added to the accumulator, sign-extended, on every valid sample.
- R7: An offset word with bit 31 set loads the accumulator with the fixed value times 2^SHIFT. The accumulator does not change while the path is in fixed mode. An offset word with bit 31 clear selects automatic mode and leaves the accumulator as it is, so tracking resumes from the last loaded or tracked value.
- R8: `outValid` is high exactly one cycle after a cycle with `inValid` high. When no sample arrives, `outI` and `outQ` hold their last values.
- R9: The I and Q paths are independent. Configuring or tracking one path has no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration word address |
| cfgWrData | input | 32 | Configuration write data |
| adcA | input | 14 | Signed sample from converter A |
| adcB | input | 14 | Signed sample from converter B |
| inValid | input | 1 | Input sample strobe |
| outI | output | 14 | Corrected signed I sample |
| outQ | output | 14 | Corrected signed Q sample |
| outValid | output | 1 | Output sample strobe |

## Verification
The bench sweeps all sixteen selector words. A decoder that treats code 11 as a converter, or that swaps the I and Q fields, shows up as a wrong source on one lane.

A grid of extreme inputs and offsets goes after saturation. A subtractor that wraps would turn 8191 minus -8192 into a negative number.

In automatic mode the bench runs a floor-division model of the integrator over long runs of samples. A truncating shift, a missing sign extension or an accumulator that keeps moving during fixed mode drifts away from that model within a few samples. Offset writes with bit 31 set and then clear, with junk in the low bits, catch an integrator that is not preloaded or that is reloaded by an automatic-mode write.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;

  // number of downconverter input lanes: 0 = I, 1 = Q
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    CFG_MUX   = 2'd0,
    CFG_OFS_I = 2'd1,
    CFG_OFS_Q = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_addr_e;

  typedef enum logic [1:0] {
    SRC_A     = 2'b00,
    SRC_B     = 2'b01,
    SRC_ZERO0 = 2'b10,
    SRC_ZERO1 = 2'b11
  } src_code_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] loadAcc;   // preload integrator of a lane
  } dc_strobe_t;

endpackage

// File: rtl/rxfe_ctrl.sv
module rxfe_ctrl
  import rxfe_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int CFG_W    = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               cfgWrEn,
  input  logic [1:0]                         cfgAddr,
  input  logic [CFG_W-1:0]                   cfgWrData,
  output logic [LANES-1:0][1:0]              srcCode,
  output logic [LANES-1:0]                   fixedMode,
  output logic [LANES-1:0][SAMPLE_W-1:0]     fixedOff,
  output logic [SAMPLE_W-1:0]                loadVal,
  output dc_strobe_t                         strobe
);

  localparam int MODE_BIT = CFG_W - 1;
  localparam int SEL_W    = 2 * LANES;
  localparam logic [SEL_W-1:0] SEL_RESET = 4'b0100;

  logic modeReq;
  logic unusedCfgBits;

  assign modeReq       = cfgWrData[MODE_BIT];
  assign loadVal       = cfgWrData[SAMPLE_W-1:0];
  assign unusedCfgBits = ^cfgWrData[MODE_BIT-1:SAMPLE_W];

  // per-lane address match and preload strobe
  logic [LANES-1:0] laneHit;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      laneHit[l]        = cfgWrEn && (cfgAddr == 2'(int'(CFG_OFS_I) + l));
      strobe.loadAcc[l] = laneHit[l] && modeReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcCode   <= SEL_RESET;
      fixedMode <= '0;
      fixedOff  <= '0;
    end else begin
      if (cfgWrEn && (cfg_addr_e'(cfgAddr) == CFG_MUX)) begin
        srcCode <= cfgWrData[SEL_W-1:0];
      end
      for (int l = 0; l < LANES; l++) begin
        if (laneHit[l]) begin
          fixedMode[l] <= modeReq;
          if (modeReq) begin
            fixedOff[l] <= cfgWrData[SAMPLE_W-1:0];
          end
        end
      end
    end
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.loadAcc)); // R2

  AST_MUX_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == 2'd0) |=> (srcCode == $past(cfgWrData[SEL_W-1:0]))); // R2

  AST_MODE_I: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == 2'd1) |=> (fixedMode[0] == $past(cfgWrData[MODE_BIT]))); // R4

  AST_MODE_Q_SEPARATE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == 2'd1) |=> $stable(fixedMode[1])); // R9

endmodule

// File: rtl/rxfe_dcpath.sv
module rxfe_dcpath #(
  parameter int SAMPLE_W = 14,
  parameter int SHIFT    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  logic                       fixedMode,
  input  logic signed [SAMPLE_W-1:0] fixedOff,
  input  logic                       loadAcc,
  input  logic        [SAMPLE_W-1:0] loadVal,
  output logic signed [SAMPLE_W-1:0] sampleOut
);

  localparam int ACC_W  = SAMPLE_W + SHIFT;
  localparam int DIFF_W = SAMPLE_W + 1;
  localparam logic signed [SAMPLE_W-1:0] MAX_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] MIN_V = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [ACC_W-1:0]    accQ;
  logic signed [SAMPLE_W-1:0] estimate;
  logic signed [SAMPLE_W-1:0] offsetSel;
  logic signed [DIFF_W-1:0]   diff;
  logic signed [SAMPLE_W-1:0] corrected;

  // estimate is the integer part of the integrator
  assign estimate  = accQ[ACC_W-1:SHIFT];
  assign offsetSel = fixedMode ? fixedOff : estimate;
  assign diff      = {sampleIn[SAMPLE_W-1], sampleIn} - {offsetSel[SAMPLE_W-1], offsetSel};

  // clamp on signed overflow of the one-bit-wider difference
  always_comb begin
    if (diff[DIFF_W-1] != diff[DIFF_W-2]) begin
      corrected = diff[DIFF_W-1] ? MIN_V : MAX_V;
    end else begin
      corrected = diff[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (loadAcc) begin
      accQ <= {loadVal, {SHIFT{1'b0}}};
    end else if (sampleValid && !fixedMode) begin
      accQ <= accQ + {{SHIFT{corrected[SAMPLE_W-1]}}, corrected};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
    end else if (sampleValid) begin
      sampleOut <= corrected;
    end
  end

  AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !sampleIn[SAMPLE_W-1] && offsetSel[SAMPLE_W-1]) |=> !sampleOut[SAMPLE_W-1]); // R5

  AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleIn[SAMPLE_W-1] && !offsetSel[SAMPLE_W-1]) |=> sampleOut[SAMPLE_W-1]); // R5

  AST_FIXED_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (fixedMode && !loadAcc) |=> $stable(accQ)); // R7

  AST_PRELOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadAcc |=> (estimate == $signed($past(loadVal)))); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(sampleOut)); // R8

endmodule

// File: rtl/rxfe_datapath.sv
module rxfe_datapath
  import rxfe_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int SHIFT    = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic signed [SAMPLE_W-1:0]     adcA,
  input  logic signed [SAMPLE_W-1:0]     adcB,
  input  logic                           inValid,
  input  logic [LANES-1:0][1:0]          srcCode,
  input  logic [LANES-1:0]               fixedMode,
  input  logic [LANES-1:0][SAMPLE_W-1:0] fixedOff,
  input  logic [SAMPLE_W-1:0]            loadVal,
  input  dc_strobe_t                     strobe,
  output logic [LANES-1:0][SAMPLE_W-1:0] laneOut,
  output logic                           outValid
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [SAMPLE_W-1:0] picked;
    logic signed [SAMPLE_W-1:0] laneRes;

    always_comb begin
      case (src_code_e'(srcCode[l]))
        SRC_A:   picked = adcA;
        SRC_B:   picked = adcB;
        default: picked = '0;
      endcase
    end

    AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && srcCode[l][1] && fixedMode[l] && fixedOff[l] == '0) |=> (laneOut[l] == '0)); // R3

    rxfe_dcpath #(
      .SAMPLE_W(SAMPLE_W),
      .SHIFT   (SHIFT)
    ) dc_i (
      .clk        (clk),
      .rstN       (rstN),
      .sampleIn   (picked),
      .sampleValid(inValid),
      .fixedMode  (fixedMode[l]),
      .fixedOff   ($signed(fixedOff[l])),
      .loadAcc    (strobe.loadAcc[l]),
      .loadVal    (loadVal),
      .sampleOut  (laneRes)
    );

    assign laneOut[l] = laneRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R8

endmodule

// File: rtl/rxfe_front.sv
module rxfe_front
  import rxfe_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int SHIFT    = 4,
  parameter int CFG_W    = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWrEn,
  input  logic [1:0]                 cfgAddr,
  input  logic [CFG_W-1:0]           cfgWrData,
  input  logic signed [SAMPLE_W-1:0] adcA,
  input  logic signed [SAMPLE_W-1:0] adcB,
  input  logic                       inValid,
  output logic signed [SAMPLE_W-1:0] outI,
  output logic signed [SAMPLE_W-1:0] outQ,
  output logic                       outValid
);

  logic [LANES-1:0][1:0]          srcCode;
  logic [LANES-1:0]               fixedMode;
  logic [LANES-1:0][SAMPLE_W-1:0] fixedOff;
  logic [SAMPLE_W-1:0]            loadVal;
  dc_strobe_t                     strobe;
  logic [LANES-1:0][SAMPLE_W-1:0] laneOut;

  rxfe_ctrl #(
    .SAMPLE_W(SAMPLE_W),
    .CFG_W   (CFG_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .srcCode  (srcCode),
    .fixedMode(fixedMode),
    .fixedOff (fixedOff),
    .loadVal  (loadVal),
    .strobe   (strobe)
  );

  rxfe_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .SHIFT   (SHIFT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .adcA     (adcA),
    .adcB     (adcB),
    .inValid  (inValid),
    .srcCode  (srcCode),
    .fixedMode(fixedMode),
    .fixedOff (fixedOff),
    .loadVal  (loadVal),
    .strobe   (strobe),
    .laneOut  (laneOut),
    .outValid (outValid)
  );

  assign outI = laneOut[0];
  assign outQ = laneOut[1];

endmodule

// File: tb/rxfe_front_tb_top.sv
`timescale 1ns/1ps
module rxfe_front_tb_top;

  localparam int SH = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [1:0]        cfgAddr = '0;
  logic [31:0]       cfgWrData = '0;
  logic signed [13:0] adcA = '0;
  logic signed [13:0] adcB = '0;
  logic              inValid = 1'b0;
  logic signed [13:0] outI;
  logic signed [13:0] outQ;
  logic              outValid;

  int errors = 0;
  int checks = 0;

  // bench model state
  longint accM [2];
  bit     fixM [2];
  longint fixV [2];
  int     muxM;
  bit     pendValid = 0;
  longint pendI, pendQ;
  string  pendTag;
  longint lastI = 0, lastQ = 0;

  always #10 clk = ~clk;

  rxfe_front dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .adcA(adcA), .adcB(adcB), .inValid(inValid),
    .outI(outI), .outQ(outQ), .outValid(outValid)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat14(input longint x);
    if (x > 8191) return 8191;
    if (x < -8192) return -8192;
    return x;
  endfunction

  function automatic longint pickSrc(input int code, input longint a, input longint b);
    if (code == 0) return a;
    if (code == 1) return b;
    return 0;
  endfunction

  function automatic longint laneStep(input int l, input longint smp);
    longint off;
    longint res;
    off = fixM[l] ? fixV[l] : (accM[l] >>> SH);
    res = sat14(smp - off);
    if (!fixM[l]) accM[l] = accM[l] + res;
    return res;
  endfunction

  // compare outputs against what the previous cycle should have produced
  task automatic observe();
    if (pendValid) begin
      chk(pendTag, "outValid", longint'(outValid), 1);
      chk(pendTag, "outI", longint'(outI), pendI);
      chk(pendTag, "outQ", longint'(outQ), pendQ);
      lastI = pendI;
      lastQ = pendQ;
    end else begin
      chk("R8", "outValid idle", longint'(outValid), 0);
      chk("R8", "outI hold", longint'(outI), lastI);
      chk("R8", "outQ hold", longint'(outQ), lastQ);
    end
  endtask

  task automatic drive(input longint a, input longint b, input string tag);
    @(negedge clk);
    observe();
    adcA = 14'(a);
    adcB = 14'(b);
    inValid = 1'b1;
    pendI = laneStep(0, pickSrc(muxM & 3, a, b));
    pendQ = laneStep(1, pickSrc((muxM >> 2) & 3, a, b));
    pendTag = tag;
    pendValid = 1;
  endtask

  task automatic idle();
    @(negedge clk);
    observe();
    inValid = 1'b0;
    pendValid = 0;
  endtask

  task automatic wrCfg(input int addr, input logic [31:0] data);
    idle();
    @(negedge clk);
    observe();
    cfgWrEn = 1'b1;
    cfgAddr = 2'(addr);
    cfgWrData = data;
    if (addr == 0) muxM = int'(data[3:0]);
    else if (addr == 1 || addr == 2) begin
      if (data[31]) begin
        fixM[addr-1] = 1;
        fixV[addr-1] = longint'($signed(data[13:0]));
        accM[addr-1] = fixV[addr-1] * (longint'(1) << SH);
      end else begin
        fixM[addr-1] = 0;
      end
    end
    @(negedge clk);
    observe();
    cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint offs [6] = '{-8192, -1, 0, 1, 5000, 8191};
    longint ins  [6] = '{-8192, -3000, -1, 0, 1, 8191};
    accM[0] = 0; accM[1] = 0; fixM[0] = 0; fixM[1] = 0;
    fixV[0] = 0; fixV[1] = 0; muxM = 4;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "outValid reset", longint'(outValid), 0);
    chk("R1", "outI reset", longint'(outI), 0);
    chk("R1", "outQ reset", longint'(outQ), 0);
    rstN = 1'b1;

    // R1: default routing and zero estimates
    drive(100, -200, "R1");
    idle();
    idle();

    // R3: full selector sweep in fixed mode with zero offset
    wrCfg(1, 32'h8000_0000);
    wrCfg(2, 32'h8000_0000);
    for (int code = 0; code < 16; code++) begin
      wrCfg(0, 32'(code));
      drive(1234, -4321, "R3");
      drive(-8192, 8191, "R3");
      drive(7, 0, "R3");
      idle();
    end
    // R2: write to unused address is ignored
    wrCfg(3, 32'hFFFF_FFFF);
    drive(55, 66, "R2");
    idle();

    // R4 R5: fixed subtraction grid with saturation
    wrCfg(0, 32'h4);
    for (int o = 0; o < 6; o++) begin
      wrCfg(1, 32'h8000_0000 | 32'(offs[o] & 14'h3FFF));
      wrCfg(2, 32'h8000_0000 | 32'((-offs[o] - 1) & 14'h3FFF));
      for (int k = 0; k < 6; k++) begin
        drive(ins[k], ins[5-k], "R5");
      end
      idle();
    end

    // R7: preload I then return to automatic mode; Q stays fixed (R9)
    wrCfg(1, 32'h8000_0000 | 32'(300));
    wrCfg(1, 32'h0000_0000);
    for (int k = 0; k < 60; k++) drive(1000, 20 * k - 600, "R6");
    idle();

    // R6 R9: both automatic, Q from preloaded -500, alternating pattern
    wrCfg(2, 32'h8000_0000 | 32'((-500) & 14'h3FFF));
    wrCfg(2, 32'h0000_1234);
    for (int k = 0; k < 80; k++) begin
      drive((k % 2 == 0) ? 8000 : -7000, -3 * k, "R9");
    end
    idle();

    // R7: freeze in fixed mode, then resume from loaded value
    wrCfg(1, 32'h8000_0000 | 32'(50));
    for (int k = 0; k < 10; k++) drive(-2000 + k, 4000, "R7");
    wrCfg(1, 32'h0000_0ABC);
    for (int k = 0; k < 20; k++) drive(-2000, 4000, "R7");
    idle();

    // R8: back-to-back stream then idle cycles with hold
    for (int k = 0; k < 8; k++) drive(k * 100, -k * 100, "R8");
    idle();
    idle();
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule